// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in-first-out buffer whose producer and consumer run on unrelated clocks. Either clock may be the faster one, and a word can be written and another read in the same moment. The storage is a small register array. Write and read positions cross between the two clock domains as Gray code through two-stage synchronisers. Full, half-full and almost-full are worked out on the write side. Empty and almost-empty are worked out on the read side.

Two handshake styles are available, and the choice is sampled while master reset is held. In the request-driven style, `statusRd` means "empty" and `statusWr` means "full", and a word moves onto `dout` only on the read-clock edge that accepts a read. In the fall-through style, `statusRd` means "a word is waiting on `dout`" and `statusWr` means "room for another write". The oldest word is placed on `dout` without any read request. Each almost-empty and almost-full threshold is a 16-bit value. Master reset sets both thresholds to one of two built-in values. After that they can be changed, either bytewise over the data bus or one bit per write clock through a serial input. A partial reset empties the buffer and keeps the thresholds and the chosen style. A rewind input sends the read position back to the first location, so the stored data can be read again.

Top module: `twoclk_fifo`

## Requirements
- R1: Words leave in the order they were written, including while writes on `wclk` and reads on `rclk` overlap at unrelated clock rates.
- R2: In request-driven style (`fwftSel`=0 at master reset), `statusRd`=1 when nothing is stored. `dout` changes only on an `rclk` edge where `ren`=1 and `statusRd`=0, and that edge loads the oldest word.
- R3: A write (`wen`=1, `loadEn`=0) while full changes no stored word and no position. A read while empty leaves `dout` unchanged.
- R4: In request-driven style, `statusWr`=1 exactly when DEPTH words are held.
- R5: `halfFull`=1 when the write-side occupancy is greater than DEPTH/2.
- R6: `almostEmpty`=1 when the read-side occupancy is at or below the empty threshold. `almostFull`=1 when the free space (DEPTH minus occupancy) is at or below the full threshold. In fall-through style, a word held on `dout` counts toward the read-side occupancy.
- R7: At master reset, both thresholds take DEF0 when `cfgSel`=0 and DEF1 when `cfgSel`=1.
- R8: While `loadEn`=1, each `wen` write stores `din[7:0]` into the threshold bytes and not into the buffer. The bytes are filled in this order: empty-threshold low, empty-threshold high, full-threshold low, full-threshold high. The order restarts whenever `loadEn` is 0.
- R9: While `loadEn`=1, `serEn`=1 and `wen`=0, each `wclk` edge shifts `serIn` into the 32-bit threshold chain. After 32 shifts, the first bit sits at empty-threshold bit 0 and the 17th bit sits at full-threshold bit 0.
- R10: Master reset empties the buffer, clears `dout` to 0 and latches `fwftSel` as the handshake style.
- R11: Partial reset empties the buffer and clears `dout`, and keeps both thresholds and the handshake style.
- R12: Asserting `rt` returns the read position to location 0, so the next words read are the first words written since reset.
- R13: In fall-through style, `statusRd` rises and the oldest word appears on `dout` without `ren`. `statusWr` is the inverse of full.
- R14: `dout` reads 0 while `oe`=0, and shows the output register while `oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wen | input | 1 | Write enable (a threshold byte while `loadEn`=1) |
| din | input | DATA_W | Write data |
| loadEn | input | 1 | Routes writes or serial bits to the thresholds |
| serEn | input | 1 | Serial threshold shift enable |
| serIn | input | 1 | Serial threshold bit |
| rclk | input | 1 | Read clock |
| ren | input | 1 | Read enable |
| oe | input | 1 | Output enable; 0 forces `dout` to zero |
| rt | input | 1 | Rewind the read position to location 0 |
| mrst | input | 1 | Master reset, synchronous to both clocks |
| prst | input | 1 | Partial reset, synchronous to both clocks |
| fwftSel | input | 1 | Handshake style sampled during master reset (1 = fall-through) |
| cfgSel | input | 1 | Chooses the default threshold at master reset |
| dout | output | DATA_W | Read data |
| statusRd | output | 1 | Empty (request-driven) or word-ready (fall-through) |
| statusWr | output | 1 | Full (request-driven) or room-available (fall-through) |
| halfFull | output | 1 | Occupancy above DEPTH/2 |
| almostEmpty | output | 1 | Occupancy at or below the empty threshold |
| almostFull | output | 1 | Free space at or below the full threshold |

## Verification
The properties assume a few things about the inputs:
- Each reset stays high for several edges of both clocks.
- The thresholds are loaded only while the read side is idle, because the read domain uses them directly.
- `rt` is raised only while writes are idle, and only when no more than DEPTH words have been written since the last reset, so the Gray pointer never jumps while being sampled.

The stimulus keeps to these limits. It holds every reset for four read-clock periods, and it runs threshold loads and rewinds between traffic phases. It issues a write only when the write-side flag, seen between edges, shows room.

// File: rtl/twoclk_fifo_pkg.sv
package twoclk_fifo_pkg;

  // Width of each programmable threshold: two bytes.
  localparam int OFS_W = 16;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrStb;     // store din at the write address
    logic fetchStb;  // load output register from the read address
    logic outClr;    // clear output register (reset)
  } strobe_t;

  // Byte slot for parallel threshold loading; the order is behaviour.
  typedef enum logic [1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } ld_slot_e;

endpackage

// File: rtl/twoclk_fifo_sync.sv
module twoclk_fifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/twoclk_fifo_ctrl.sv
module twoclk_fifo_ctrl
  import twoclk_fifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEF0   = 2,
  parameter int DEF1   = 5
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              fwftSel,
  input  logic              cfgSel,
  input  logic              wen,
  input  logic              ren,
  input  logic              rt,
  input  logic              loadEn,
  input  logic              serEn,
  input  logic              serIn,
  input  logic [7:0]        ldByte,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullW,
  output logic              halfFull,
  output logic              almostFull,
  output logic              memEmpty,
  output logic              outValid,
  output logic              almostEmpty,
  output logic              modeW,
  output logic              modeR
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
  localparam logic [OFS_W-1:0] DEF0_O = OFS_W'(DEF0);
  localparam logic [OFS_W-1:0] DEF1_O = OFS_W'(DEF1);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic anyRst;
  assign anyRst = mrst | prst;

  // ---------------- write domain ----------------
  logic [PW-1:0] wBin, wGray, rGraySync, rBinSync, wOcc, wFree;
  logic [OFS_W-1:0] aeOfs, afOfs;
  ld_slot_e slot;
  logic wrAccept;

  twoclk_fifo_sync #(.W(PW)) u_syncR2W (
    .clk(wclk), .rst(anyRst), .d(toGray(rBin)), .q(rGraySync)
  );

  assign rBinSync   = fromGray(rGraySync);
  assign wOcc       = wBin - rBinSync;
  assign wFree      = DEPTH_P - wOcc;
  assign fullW      = (wOcc == DEPTH_P);
  assign halfFull   = (wOcc > HALF_P);
  assign almostFull = ({{(OFS_W-PW){1'b0}}, wFree} <= afOfs);
  assign wrAccept   = wen && !loadEn && !fullW && !anyRst;
  assign wrAddr     = wBin[ADDR_W-1:0];

  always_ff @(posedge wclk) begin
    if (anyRst) begin
      wBin  <= '0;
      wGray <= '0;
    end else if (wrAccept) begin
      wBin  <= wBin + 1'b1;
      wGray <= toGray(wBin + 1'b1);
    end
  end

  always_ff @(posedge wclk) begin
    if (mrst) modeW <= fwftSel;
  end

  always_ff @(posedge wclk) begin
    if (mrst) begin
      aeOfs <= cfgSel ? DEF1_O : DEF0_O;
      afOfs <= cfgSel ? DEF1_O : DEF0_O;
      slot  <= SLOT_AE_LO;
    end else if (prst || !loadEn) begin
      slot <= SLOT_AE_LO;
    end else if (wen) begin
      unique case (slot)
        SLOT_AE_LO: aeOfs[7:0]  <= ldByte;
        SLOT_AE_HI: aeOfs[15:8] <= ldByte;
        SLOT_AF_LO: afOfs[7:0]  <= ldByte;
        SLOT_AF_HI: afOfs[15:8] <= ldByte;
        default: ;
      endcase
      slot <= ld_slot_e'(slot + 2'd1);
    end else if (serEn) begin
      {afOfs, aeOfs} <= {serIn, afOfs, aeOfs[OFS_W-1:1]};
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rBin, wGraySync, wBinSync, memOcc, rOcc;
  logic fetch;

  twoclk_fifo_sync #(.W(PW)) u_syncW2R (
    .clk(rclk), .rst(anyRst), .d(wGray), .q(wGraySync)
  );

  assign wBinSync = fromGray(wGraySync);
  assign memOcc   = wBinSync - rBin;
  assign memEmpty = (memOcc == '0);
  assign rOcc     = memOcc + PW'(outValid);
  assign almostEmpty = ({{(OFS_W-PW){1'b0}}, rOcc} <= aeOfs);
  assign rdAddr   = rBin[ADDR_W-1:0];

  always_comb begin
    if (anyRst || rt)  fetch = 1'b0;
    else if (modeR)    fetch = !memEmpty && (!outValid || ren);
    else               fetch = !memEmpty && ren;
  end

  always_ff @(posedge rclk) begin
    if (mrst) modeR <= fwftSel;
  end

  always_ff @(posedge rclk) begin
    if (anyRst || rt) begin
      rBin     <= '0;
      outValid <= 1'b0;
    end else begin
      if (fetch) rBin <= rBin + 1'b1;
      if (modeR) begin
        if (fetch)    outValid <= 1'b1;
        else if (ren) outValid <= 1'b0;
      end
    end
  end

  assign stb.wrStb    = wrAccept;
  assign stb.fetchStb = fetch;
  assign stb.outClr   = anyRst;
endmodule

// File: rtl/twoclk_fifo_dp.sv
module twoclk_fifo_dp
  import twoclk_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              rclk,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] doutQ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (stb.wrStb) mem[wrAddr] <= din;
  end

  always_ff @(posedge rclk) begin
    if (stb.outClr)        doutQ <= '0;
    else if (stb.fetchStb) doutQ <= mem[rdAddr];
  end
endmodule

// File: rtl/twoclk_fifo.sv
module twoclk_fifo
  import twoclk_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4,
  parameter int DEF0   = 2,
  parameter int DEF1   = 5
) (
  input  logic              wclk,
  input  logic              wen,
  input  logic [DATA_W-1:0] din,
  input  logic              loadEn,
  input  logic              serEn,
  input  logic              serIn,
  input  logic              rclk,
  input  logic              ren,
  input  logic              oe,
  input  logic              rt,
  input  logic              mrst,
  input  logic              prst,
  input  logic              fwftSel,
  input  logic              cfgSel,
  output logic [DATA_W-1:0] dout,
  output logic              statusRd,
  output logic              statusWr,
  output logic              halfFull,
  output logic              almostEmpty,
  output logic              almostFull
);
  strobe_t           stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              fullW, memEmpty, outValid, modeW, modeR;
  logic [DATA_W-1:0] doutQ;

  twoclk_fifo_ctrl #(.ADDR_W(ADDR_W), .DEF0(DEF0), .DEF1(DEF1)) u_ctrl (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
    .fwftSel(fwftSel), .cfgSel(cfgSel), .wen(wen), .ren(ren), .rt(rt),
    .loadEn(loadEn), .serEn(serEn), .serIn(serIn), .ldByte(din[7:0]),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullW(fullW), .halfFull(halfFull), .almostFull(almostFull),
    .memEmpty(memEmpty), .outValid(outValid), .almostEmpty(almostEmpty),
    .modeW(modeW), .modeR(modeR)
  );

  twoclk_fifo_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .wclk(wclk), .rclk(rclk), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .din(din), .doutQ(doutQ)
  );

  assign dout     = oe ? doutQ : '0;
  assign statusRd = modeR ? outValid : memEmpty;
  assign statusWr = modeW ? !fullW : fullW;
endmodule

// File: rtl/twoclk_fifo_chk.sv
module twoclk_fifo_chk #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input logic              wclk,
  input logic              rclk,
  input logic              mrst,
  input logic              prst,
  input logic              ren,
  input logic              rt,
  input logic              modeR,
  input logic              fullW,
  input logic              halfFull,
  input logic              almostFull,
  input logic              memEmpty,
  input logic              outValid,
  input logic              almostEmpty,
  input logic [DATA_W-1:0] doutQ,
  input logic [ADDR_W-1:0] rdAddr
);
  // R5: a full buffer is always above half.
  p_full_half_r5: assert property (@(posedge wclk) disable iff (mrst || prst)
    fullW |-> halfFull);

  // R6: a full buffer has no free space, so almost-full must hold.
  p_full_af_r6: assert property (@(posedge wclk) disable iff (mrst || prst)
    fullW |-> almostFull);

  // R6: nothing stored and nothing held means almost-empty.
  p_empty_ae_r6: assert property (@(posedge rclk) disable iff (mrst || prst)
    (memEmpty && !outValid) |-> almostEmpty);

  // R3: request-driven read while empty leaves the output register alone.
  p_empty_hold_r3: assert property (@(posedge rclk) disable iff (mrst || prst)
    (!modeR && memEmpty && !rt) |=> $stable(doutQ));

  // R13: a presented word stays until it is read.
  p_fwft_hold_r13: assert property (@(posedge rclk) disable iff (mrst || prst)
    (modeR && outValid && !ren && !rt) |=> (outValid && $stable(doutQ)));

  // R12: rewind lands on location 0.
  p_rewind_r12: assert property (@(posedge rclk) disable iff (mrst || prst)
    rt |=> (rdAddr == '0));

  // R11: only master reset may change the handshake style.
  p_mode_kept_r11: assert property (@(posedge rclk) disable iff (mrst)
    !mrst |=> $stable(modeR));
endmodule

bind twoclk_fifo twoclk_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .ren(ren), .rt(rt),
  .modeR(modeR), .fullW(fullW), .halfFull(halfFull), .almostFull(almostFull),
  .memEmpty(memEmpty), .outValid(outValid), .almostEmpty(almostEmpty),
  .doutQ(doutQ), .rdAddr(rdAddr)
);

// File: tb/twoclk_fifo_test.sv
`timescale 1ns/1ps
module twoclk_fifo_test;
  localparam int DATA_W = 9;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wclk = 0, rclk = 0;
  logic wen = 0, loadEn = 0, serEn = 0, serIn = 0;
  logic ren = 0, oe = 1, rt = 0;
  logic mrst = 1, prst = 0, fwftSel = 0, cfgSel = 0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic statusRd, statusWr, halfFull, almostEmpty, almostFull;

  int checks = 0, fails = 0;
  bit benchFwft = 0, done = 0;
  logic [DATA_W-1:0] expQ[$];

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  twoclk_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .wclk(wclk), .wen(wen), .din(din), .loadEn(loadEn), .serEn(serEn),
    .serIn(serIn), .rclk(rclk), .ren(ren), .oe(oe), .rt(rt), .mrst(mrst),
    .prst(prst), .fwftSel(fwftSel), .cfgSel(cfgSel), .dout(dout),
    .statusRd(statusRd), .statusWr(statusWr), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares each consumed word against the scoreboard.
  always @(posedge rclk) begin
    if (!mrst && !prst && ren) begin
      if (benchFwft) begin
        if (statusRd) begin
          if (expQ.size() == 0) chk("R1 unexpected fwft word", dout, 0);
          else chk("R1/R13 fwft order", dout, expQ.pop_front());
        end
      end else if (!statusRd) begin
        #1;
        if (expQ.size() == 0) chk("R2 unexpected word", dout, 0);
        else chk("R1/R2 read order", dout, expQ.pop_front());
      end
    end
  end

  task automatic doReset(input bit master, input bit fw, input bit cs);
    @(negedge wclk);
    fwftSel = fw; cfgSel = cs;
    if (master) mrst = 1; else prst = 1;
    repeat (4) @(negedge rclk);
    mrst = 0; prst = 0;
    if (master) benchFwft = fw;
    expQ.delete();
    repeat (3) @(negedge rclk);
  endtask

  task automatic writeWord(input logic [DATA_W-1:0] d, input bit push);
    @(negedge wclk);
    wen = 1; din = d;
    if (push) expQ.push_back(d);
    @(negedge wclk);
    wen = 0;
  endtask

  task automatic writeRun(input int n, input int base);
    for (int i = 0; i < n; i++) writeWord(DATA_W'(base + i), 1);
  endtask

  task automatic drain();
    @(negedge rclk);
    ren = 1;
    for (int i = 0; i < 400 && expQ.size() > 0; i++) @(negedge rclk);
    ren = 0;
    chk("R1 all words drained", expQ.size(), 0);
    repeat (6) @(negedge wclk);
  endtask

  task automatic waitR(input int n);
    repeat (n) @(negedge rclk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // ---- request-driven style, default thresholds DEF0=2 ----
    doReset(1, 0, 0);
    chk("R10 empty after reset", statusRd, 1);
    chk("R10 not full after reset", statusWr, 0);
    chk("R10 dout zero", dout, 0);
    chk("R5 halfFull reset", halfFull, 0);
    chk("R6 almostEmpty reset", almostEmpty, 1);
    chk("R6 almostFull reset", almostFull, 0);

    writeRun(8, 'h100);
    chk("R5 halfFull at DEPTH/2", halfFull, 0);
    writeWord('h108, 1);
    chk("R5 halfFull above half", halfFull, 1);
    writeRun(4, 'h109);
    chk("R7 almostFull free=3 default 2", almostFull, 0);
    writeWord('h10D, 1);
    chk("R7 almostFull free=2 default 2", almostFull, 1);
    writeRun(1, 'h10E);
    chk("R4 not full at 15", statusWr, 0);
    writeWord('h10F, 1);
    chk("R4 full at DEPTH", statusWr, 1);
    writeWord('h1AA, 0);  // ignored while full
    chk("R3 still full after blocked write", statusWr, 1);
    waitR(5);
    chk("R2 dout unchanged before any read", dout, 0);
    chk("R6 almostEmpty clear with 16", almostEmpty, 0);
    drain();
    waitR(3);
    chk("R2 empty after drain", statusRd, 1);
    @(negedge rclk); ren = 1; @(negedge rclk); ren = 0;
    chk("R3 read while empty keeps dout", dout, 'h10F);

    // ---- parallel threshold load: empty=3, full=4 ----
    @(negedge wclk); loadEn = 1;
    writeWord('h003, 0); writeWord('h000, 0);
    writeWord('h004, 0); writeWord('h000, 0);
    @(negedge wclk); loadEn = 0;
    waitR(5);
    chk("R8 load bytes not stored", statusRd, 1);
    writeRun(3, 'h020);
    waitR(5);
    chk("R8 almostEmpty occ=3 ofs=3", almostEmpty, 1);
    writeWord('h023, 1);
    waitR(5);
    chk("R8 almostEmpty occ=4 ofs=3", almostEmpty, 0);
    writeRun(7, 'h024);
    chk("R8 almostFull free=5 ofs=4", almostFull, 0);
    writeWord('h02B, 1);
    chk("R8 almostFull free=4 ofs=4", almostFull, 1);
    drain();

    // ---- partial reset keeps thresholds ----
    writeWord('h0F0, 0); writeWord('h0F1, 0);
    doReset(0, 1, 0);  // fwftSel change must not matter
    chk("R11 empty after partial reset", statusRd, 1);
    chk("R11 dout cleared", dout, 0);
    writeRun(3, 'h040);
    waitR(5);
    chk("R11 empty threshold kept (occ=3)", almostEmpty, 1);
    writeWord('h043, 1);
    waitR(5);
    chk("R11 empty threshold kept (occ=4)", almostEmpty, 0);
    drain();

    // ---- serial load: empty=6, full=1 ----
    @(negedge wclk); loadEn = 1; serEn = 1;
    for (int i = 0; i < 32; i++) begin
      serIn = (i < 16) ? ((16'd6 >> i) & 1'b1) : ((16'd1 >> (i - 16)) & 1'b1);
      @(negedge wclk);
    end
    loadEn = 0; serEn = 0; serIn = 0;
    writeRun(6, 'h060);
    waitR(5);
    chk("R9 almostEmpty occ=6 ofs=6", almostEmpty, 1);
    writeWord('h066, 1);
    waitR(5);
    chk("R9 almostEmpty occ=7 ofs=6", almostEmpty, 0);
    writeRun(7, 'h067);
    chk("R9 almostFull free=2 ofs=1", almostFull, 0);
    writeWord('h06E, 1);
    chk("R9 almostFull free=1 ofs=1", almostFull, 1);
    drain();

    // ---- rewind ----
    doReset(0, 0, 0);
    writeRun(5, 'h080);
    drain();
    @(negedge rclk); rt = 1; @(negedge rclk); rt = 0;
    for (int i = 0; i < 5; i++) expQ.push_back(DATA_W'('h080 + i));
    waitR(4);
    chk("R12 data available after rewind", statusRd, 0);
    drain();

    // ---- fall-through style, defaults DEF1=5 ----
    doReset(1, 1, 1);
    @(negedge wclk); fwftSel = 0;
    chk("R13 not ready after reset", statusRd, 0);
    chk("R13 room after reset", statusWr, 1);
    writeWord('h155, 1);
    waitR(6);
    chk("R13 ready without read", statusRd, 1);
    chk("R13 word presented", dout, 'h155);
    oe = 0; #1;
    chk("R14 oe low zeroes dout", dout, 0);
    oe = 1; #1;
    chk("R14 oe high shows word", dout, 'h155);
    writeRun(4, 'h156);
    waitR(6);
    chk("R7 almostEmpty occ=5 default 5", almostEmpty, 1);
    writeWord('h15A, 1);
    waitR(6);
    chk("R7 almostEmpty occ=6 default 5", almostEmpty, 0);
    chk("R10 style latched at reset", statusRd, 1);
    drain();
    waitR(3);
    chk("R13 not ready after drain", statusRd, 0);

    // ---- overlapping traffic ----
    fork
      begin
        int sent = 0;
        while (sent < 40) begin
          @(negedge wclk);
          if (statusWr) begin
            wen = 1; din = DATA_W'('h1C0 + sent);
            expQ.push_back(din);
            sent++;
          end else wen = 0;
          if (sent % 3 == 0) begin @(negedge wclk); wen = 0; end
        end
        @(negedge wclk); wen = 0;
      end
      begin
        @(negedge rclk); ren = 1;
        repeat (300) @(negedge rclk);
        ren = 0;
      end
    join
    chk("R1 overlapping traffic drained", expQ.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule